// File: doc/BRIEF.md
# Time-Slotted Shared Shifter Arbiter

This block lets eight small stack-processor cores use one barrel shifter. Access does not depend on who is asking: a one-hot time slot moves to the next core on every clock. A core may only use the shifter while it holds that slot. A core that raises its shift request at any other time is told to stall. It is granted when its slot comes round, and its result returns a fixed number of cycles later.

The stall output is meant to drive the hold condition of a core's state registers. While it is high, the core keeps its program counter, data stack pointer, top-of-stack and return stack pointer. In the cycle its result arrives, the stall drops, and the core loads its next state together with the shifted value.

The shifter has a latency of `LAT` clock cycles, from 1 to 3. The latency can cover a slow shift, or a long wire between the cores and the shared unit. The shift levels are spread across `LAT` register stages. A new grant can therefore enter every cycle, and each operation in flight carries the index of its owner.

Top module: `slot_shifter_arbiter`

## Requirements
- R1: During reset and in the first cycle after it, the slot output is one-hot with bit 0 set (core 0 holds the slot).
- R2: The slot moves on every clock to the next higher core index and wraps from core 7 to core 0, whether or not any request is present. In cycle n after reset the slot is held by core n mod 8.
- R3: A core requesting in cycle c is granted in the first cycle g ≥ c in which it holds the slot. Its result is presented exactly LAT cycles after g, so it is never served more than 7+LAT cycles after the request.
- R4: A core's pause output is high in every cycle in which its request is high and its result is not being presented. It is low in the cycle its result is presented, and low whenever its request is low.
- R5: The result equals the core's 16-bit operand shifted by its 4-bit amount (0 to 15), under the 2-bit mode code: 0 is logical left, 1 is logical right with zero fill, 2 is arithmetic right with sign fill, 3 is rotate left.
- R6: The one-hot result-valid output marks only the core whose operation completes, and at most one of its bits is set in any cycle. A core with no outstanding request never receives a result.
- R7: With LAT greater than 1, grants in consecutive cycles to different cores are all accepted. Each result returns to its own core with its own data, in grant order.
- R8: Operands, amounts and modes from cores that request outside their slot have no effect on the result delivered to the core being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N | Shift request, one bit per core |
| opnd_i | input | N*W | Operands, core k in bits [k*W +: W] |
| amt_i | input | N*AW | Shift amounts, core k in bits [k*AW +: AW] |
| mode_i | input | N*2 | Shift mode codes, core k in bits [k*2 +: 2] |
| slot_o | output | N | One-hot current time slot |
| pause_o | output | N | Stall request to each core |
| res_valid_o | output | N | One-hot marker of the core receiving a result this cycle |
| res_data_o | output | W | Shift result for the marked core |

## Verification
The checks assume that a core keeps its request, operand, amount and mode unchanged from the cycle it raises the request until the cycle its result is presented. It drops or replaces the request only after that cycle. They also assume that LAT is smaller than the number of cores, so a result always comes home before the same core's slot returns.

The stimulus comes from per-core requester tasks that model exactly this behaviour. Each task changes its inputs only on the falling edge, and releases its request on the falling edge of the cycle in which it sees its result. Single requests, all-core bursts and random request masks all stay within that contract.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROL = 2'd3
  } shift_mode_e;

  // True when a pipeline register follows shift level `lvl`, spreading
  // `lat` registers evenly over `levels` shift levels (last always cut).
  function automatic bit level_cut(int lvl, int lat, int levels);
    return (((lvl + 1) * lat) / levels) > ((lvl * lat) / levels);
  endfunction

endpackage

// File: rtl/ssa_slot_ring.sv
module ssa_slot_ring #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] slot_o
);

  logic [N-1:0] tok_q;
  logic [N-1:0] tok_d;
  logic         tok_en;

  always_comb begin
    tok_en = 1'b1;
    tok_d  = {tok_q[N-2:0], tok_q[N-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tok_q <= N'(1);
    else if (tok_en) tok_q <= tok_d;
  end

  assign slot_o = tok_q;

endmodule

// File: rtl/ssa_operand_mux.sv
module ssa_operand_mux #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int AW = 4,
  localparam int TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    grant_i,
  input  logic [N*W-1:0]  opnd_i,
  input  logic [N*AW-1:0] amt_i,
  input  logic [N*2-1:0]  mode_i,
  output logic            sel_valid_o,
  output logic [TW-1:0]   sel_tag_o,
  output logic [W-1:0]    sel_data_o,
  output logic [AW-1:0]   sel_amt_o,
  output logic [1:0]      sel_mode_o
);

  always_comb begin
    sel_valid_o = |grant_i;
    sel_tag_o   = '0;
    sel_data_o  = '0;
    sel_amt_o   = '0;
    sel_mode_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_i[i]) begin
        sel_tag_o  = sel_tag_o  | TW'(i);
        sel_data_o = sel_data_o | opnd_i[i*W +: W];
        sel_amt_o  = sel_amt_o  | amt_i[i*AW +: AW];
        sel_mode_o = sel_mode_o | mode_i[i*2 +: 2];
      end
    end
  end

endmodule

// File: rtl/ssa_shift_level.sv
module ssa_shift_level
  import ssa_pkg::*;
#(
  parameter int W     = 16,
  parameter int AW    = 4,
  parameter int TW    = 3,
  parameter int LEVEL = 0,
  parameter bit CUT   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tag,
  input  logic [1:0]    in_mode,
  input  logic [AW-1:0] in_amt,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  output logic [TW-1:0] out_tag,
  output logic [1:0]    out_mode,
  output logic [AW-1:0] out_amt,
  output logic [W-1:0]  out_data
);

  localparam int SH = 1 << LEVEL;

  logic [W-1:0] moved;
  logic [W-1:0] lvl_data;

  always_comb begin
    case (shift_mode_e'(in_mode))
      SH_LSL:  moved = in_data << SH;
      SH_LSR:  moved = in_data >> SH;
      SH_ASR:  moved = W'($signed(in_data) >>> SH);
      default: moved = (in_data << SH) | (in_data >> (W - SH));
    endcase
    lvl_data = in_amt[LEVEL] ? moved : in_data;
  end

  generate
    if (CUT) begin : g_reg
      logic          v_q;
      logic [TW-1:0] t_q;
      logic [1:0]    m_q;
      logic [AW-1:0] a_q;
      logic [W-1:0]  d_q;
      logic          load_en;

      assign load_en = in_valid;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= in_valid;
      end

      always_ff @(posedge clk) begin
        if (load_en) begin
          t_q <= in_tag;
          m_q <= in_mode;
          a_q <= in_amt;
          d_q <= lvl_data;
        end
      end

      assign out_valid = v_q;
      assign out_tag   = t_q;
      assign out_mode  = m_q;
      assign out_amt   = a_q;
      assign out_data  = d_q;
    end else begin : g_wire
      assign out_valid = in_valid;
      assign out_tag   = in_tag;
      assign out_mode  = in_mode;
      assign out_amt   = in_amt;
      assign out_data  = lvl_data;
    end
  endgenerate

endmodule

// File: rtl/slot_shifter_arbiter.sv
module slot_shifter_arbiter
  import ssa_pkg::*;
#(
  parameter int N   = 8,
  parameter int W   = 16,
  parameter int AW  = 4,
  parameter int LAT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_i,
  input  logic [N*W-1:0]  opnd_i,
  input  logic [N*AW-1:0] amt_i,
  input  logic [N*2-1:0]  mode_i,
  output logic [N-1:0]    slot_o,
  output logic [N-1:0]    pause_o,
  output logic [N-1:0]    res_valid_o,
  output logic [W-1:0]    res_data_o
);

  localparam int TW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  grant;
  logic          c_valid [0:AW];
  logic [TW-1:0] c_tag   [0:AW];
  logic [1:0]    c_mode  [0:AW];
  logic [AW-1:0] c_amt   [0:AW];
  logic [W-1:0]  c_data  [0:AW];

  ssa_slot_ring #(.N(N)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_o (slot_o)
  );

  assign grant = req_i & slot_o;

  ssa_operand_mux #(.N(N), .W(W), .AW(AW)) u_mux (
    .grant_i     (grant),
    .opnd_i      (opnd_i),
    .amt_i       (amt_i),
    .mode_i      (mode_i),
    .sel_valid_o (c_valid[0]),
    .sel_tag_o   (c_tag[0]),
    .sel_data_o  (c_data[0]),
    .sel_amt_o   (c_amt[0]),
    .sel_mode_o  (c_mode[0])
  );

  generate
    for (genvar g = 0; g < AW; g++) begin : g_lvl
      ssa_shift_level #(
        .W(W), .AW(AW), .TW(TW), .LEVEL(g),
        .CUT(level_cut(g, LAT, AW))
      ) u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (c_valid[g]),
        .in_tag    (c_tag[g]),
        .in_mode   (c_mode[g]),
        .in_amt    (c_amt[g]),
        .in_data   (c_data[g]),
        .out_valid (c_valid[g+1]),
        .out_tag   (c_tag[g+1]),
        .out_mode  (c_mode[g+1]),
        .out_amt   (c_amt[g+1]),
        .out_data  (c_data[g+1])
      );
    end
  endgenerate

  always_comb begin
    res_valid_o = c_valid[AW] ? (N'(1) << c_tag[AW]) : '0;
    res_data_o  = c_data[AW];
    pause_o     = req_i & ~res_valid_o;
  end

endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
  parameter int N   = 8,
  parameter int LAT = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_i,
  input logic [N-1:0] slot_o,
  input logic [N-1:0] pause_o,
  input logic [N-1:0] res_valid_o
);

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_o) == 1); // R1

  AST_RESULT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_valid_o)); // R6

  generate
    for (genvar k = 0; k < N; k++) begin : g_core
      AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o[k] |=> slot_o[(k + 1) % N]); // R2

      AST_RESULT_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o[k] |-> $past(slot_o[k] && req_i[k], LAT)); // R3

      AST_PAUSE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[k] && !slot_o[k] && !res_valid_o[k]) |-> pause_o[k]); // R4

      AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i[k] |-> !pause_o[k]); // R4

      AST_PAUSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o[k] |-> !pause_o[k]); // R4
    end
  endgenerate

endmodule

bind slot_shifter_arbiter ssa_checker #(.N(N), .LAT(LAT)) u_ssa_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .slot_o      (slot_o),
  .pause_o     (pause_o),
  .res_valid_o (res_valid_o)
);

// File: tb/slot_shifter_arbiter_test.sv
module slot_shifter_arbiter_test;

  localparam int N   = 8;
  localparam int W   = 16;
  localparam int AW  = 4;
  localparam int LAT = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req;
  logic [N*W-1:0]  opnd;
  logic [N*AW-1:0] amt;
  logic [N*2-1:0]  mode;
  logic [N-1:0]    slot;
  logic [N-1:0]    pause;
  logic [N-1:0]    res_valid;
  logic [W-1:0]    res_data;

  int     cyc;
  int     checks;
  int     errors;
  bit     finished;
  bit     pending [N];
  int     done_cyc [N];
  logic [W-1:0] expq [N][$];
  string  ptag;

  always #4 clk = ~clk;

  slot_shifter_arbiter #(.N(N), .W(W), .AW(AW), .LAT(LAT)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .opnd_i      (opnd),
    .amt_i       (amt),
    .mode_i      (mode),
    .slot_o      (slot),
    .pause_o     (pause),
    .res_valid_o (res_valid),
    .res_data_o  (res_data)
  );

  function automatic logic [W-1:0] ref_shift(logic [W-1:0] d, int a, int m);
    logic [W-1:0] r;
    case (m)
      0:       r = d << a;
      1:       r = d >> a;
      2:       r = W'($signed(d) >>> a);
      default: r = (a == 0) ? d : ((d << a) | (d >> (W - a)));
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Requester model for one core: hold inputs until the result is seen.
  task automatic issue(int k, logic [W-1:0] d, int a, int m);
    int c;
    @(negedge clk);
    opnd[k*W +: W]  = d;
    amt[k*AW +: AW] = AW'(a);
    mode[k*2 +: 2]  = 2'(m);
    req[k]          = 1'b1;
    c = cyc;
    while ((c % N) != k) c++;
    done_cyc[k] = c + LAT;
    expq[k].push_back(ref_shift(d, a, m));
    pending[k] = 1'b1;
    forever begin
      @(negedge clk);
      if (res_valid[k]) break;
    end
    req[k]     = 1'b0;
    pending[k] = 1'b0;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !finished) begin
        check(slot == (N'(1) << (cyc % N)), "R2 slot position", 32'(slot),
              32'(N'(1) << (cyc % N)));
        check($countones(res_valid) <= 1, "R6 result valid onehot0",
              32'(res_valid), 32'(0));
        for (int k = 0; k < N; k++) begin
          bit exp_p;
          exp_p = pending[k] && (cyc != done_cyc[k]);
          check(pause[k] == exp_p, "R4 pause level", 32'(pause[k]), 32'(exp_p));
          if (res_valid[k]) begin
            check(pending[k] && (cyc == done_cyc[k]), "R3 result cycle",
                  32'(cyc), 32'(done_cyc[k]));
            if (expq[k].size() > 0) begin
              logic [W-1:0] e;
              e = expq[k].pop_front();
              check(res_data == e, {ptag, " result data"}, 32'(res_data), 32'(e));
            end else begin
              check(1'b0, "R6 result to idle core", 32'(k), 32'(0));
            end
          end
          if (pending[k] && (cyc == done_cyc[k] + 1))
            check(1'b0, "R3 result missing", 32'(cyc), 32'(done_cyc[k]));
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      end_run();
    end
  end

  initial begin
    cyc = 0; checks = 0; errors = 0; finished = 1'b0;
    for (int k = 0; k < N; k++) begin pending[k] = 1'b0; done_cyc[k] = 0; end
    ptag  = "R5 single";
    rst_n = 1'b0;
    req   = '0;
    opnd  = '0;
    amt   = '0;
    mode  = '0;
    repeat (3) @(negedge clk);
    check(slot == N'(1), "R1 reset slot", 32'(slot), 32'(1));
    check(pause == '0, "R4 reset pause", 32'(pause), 32'(0));
    check(res_valid == '0, "R6 reset result valid", 32'(res_valid), 32'(0));
    rst_n = 1'b1;
    #2;
    check(slot == N'(1), "R1 first cycle slot", 32'(slot), 32'(1));
    repeat (20) @(negedge clk);  // idle: slot keeps rotating (R2)

    // R5 directed modes and boundary amounts, R3 waits of varying length
    issue(3, 16'h8001, 1, 0);
    issue(5, 16'h8001, 15, 1);
    issue(0, 16'h8421, 4, 2);
    issue(7, 16'hF00F, 0, 3);
    issue(2, 16'h1234, 4, 3);
    issue(6, 16'h8000, 15, 2);
    issue(1, 16'hABCD, 15, 3);
    issue(4, 16'hFFFF, 15, 0);
    issue(4, 16'h7FFF, 15, 2);   // same core back to back
    issue(4, 16'h0001, 0, 1);

    // R7 R8: all cores request together, grants in consecutive cycles
    ptag = "R7 R8 burst";
    for (int rep = 0; rep < 3; rep++) begin
      for (int k = 0; k < N; k++) begin
        automatic int kk = k;
        automatic int aa = (k * 5 + rep) % 16;
        automatic int mm = (k + rep) % 4;
        automatic logic [W-1:0] dd = W'(16'h9C35 ^ (k * 16'h1111) ^ (rep << 3));
        fork issue(kk, dd, aa, mm); join_none
      end
      wait fork;
    end

    // R8 random request masks with random operands
    ptag = "R8 random";
    for (int r = 0; r < 80; r++) begin
      automatic logic [N-1:0] mask = N'($urandom);
      for (int k = 0; k < N; k++) begin
        if (mask[k]) begin
          automatic int kk = k;
          automatic int aa = int'($urandom % 16);
          automatic int mm = int'($urandom % 4);
          automatic logic [W-1:0] dd = W'($urandom);
          fork issue(kk, dd, aa, mm); join_none
        end
      end
      wait fork;
      if (r % 7 == 0) @(negedge clk);
    end

    repeat (10) @(negedge clk);
    end_run();
  end

endmodule